// File: doc/BRIEF.md
# Two-Core Quota-Driven Recency Stack Controller

This block keeps the replacement order of a single set in a cache that two cores share. The order is a ranked list of way indices. Slot 0 is the most recently used end and the last slot is the least recently used end. The block does not store tags or data, and it does not decide how much space each core deserves. Each core's way quota arrives as an input. The block uses that quota to decide where that core's newly filled lines enter the list.

On a miss, the way at the bottom of the list is the victim. That same way index is then reused for the incoming line and is placed a quota's worth of positions up from the bottom. A core with a small quota therefore sees its fresh lines age out quickly. On a hit, the line climbs only one rank. Frequently reused lines earn their way to the top gradually instead of jumping there. Together these two rules give a soft partition between the cores without any explicit per-core ownership bits.

The victim output is combinational from the stored order, so a tag pipeline can read it in the same cycle it reports the miss. Every request updates the stored order at the next rising clock edge.

Top module: `pipp_set_ctrl`

## Requirements
- R1: After reset, slot i of `rank_vec` (bits [i*WW +: WW], slot 0 = MRU end, slot WAYS-1 = LRU end) holds way index i.
- R2: `victim_way` always equals the way index held in slot WAYS-1 of the current order.
- R3: On a miss with an effective quota q, the way taken from slot WAYS-1 moves to slot WAYS-q. Slots WAYS-q .. WAYS-2 each move one slot toward the LRU end. Slots above WAYS-q keep their contents.
- R4: The quota used is field c of `quota_vec` (bits [c*QW +: QW]), where c is `req_core`; core 0 is in the low bits.
- R5: A quota of 0 is treated as 1. The evicted way stays in slot WAYS-1 and the order is unchanged.
- R6: A quota of WAYS or more is treated as WAYS. The evicted way goes to slot 0.
- R7: On a hit to a way held in slot k > 0, that way and the way in slot k-1 exchange places. All other slots are unchanged.
- R8: A hit to the way held in slot 0 leaves the order unchanged.
- R9: While `req_valid` is low, the order does not change, whatever the other request inputs are.
- R10: Each request's new order is visible on `rank_vec` after the first rising clock edge at which it is presented.
- R11: The order is always a permutation: every way index from 0 to WAYS-1 appears in exactly one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A hit or miss is presented this cycle |
| req_core | input | CW | Requesting core index |
| req_hit | input | 1 | 1 = hit on `hit_way`, 0 = miss |
| hit_way | input | WW | Way that hit (ignored on a miss) |
| quota_vec | input | NCORES*QW | Per-core way quotas, core c at [c*QW +: QW] |
| victim_way | output | WW | Way to evict on a miss (LRU end of the order) |
| rank_vec | output | WAYS*WW | Current order, slot i at [i*WW +: WW], slot 0 = MRU |

## Verification
`victim_way` depends only on stored state, so the bench reads it in the cycle where a request is being presented, before the clock edge that consumes it. The new order lands one rising edge after the request. The bench drives each request just after a falling edge, holds it across exactly one rising edge, and drops `req_valid` shortly after that edge. It compares the whole order at the following falling edge, against a model updated once per request. Idle cycles get the same treatment, so any extra or missing update shows up in the very next comparison.

// File: rtl/pipp_pkg.sv
package pipp_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_HIT  = 2'd1,
      OP_MISS = 2'd2
   } stack_op_e;

   function automatic stack_op_e classify(input logic valid, input logic hit);
      if (!valid)  return OP_IDLE;
      else if (hit) return OP_HIT;
      else          return OP_MISS;
   endfunction

endpackage

// File: rtl/pipp_quota_sel.sv
module pipp_quota_sel #(
   parameter int WAYS   = 8,
   parameter int NCORES = 2,
   parameter int QW     = 4,
   localparam int WW    = $clog2(WAYS),
   localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
   input  logic [CW-1:0]        core,
   input  logic [NCORES*QW-1:0] quota_vec,
   output logic [WW-1:0]        ins_slot
);

   logic [QW-1:0] quota_raw;
   int            quota_eff;

   // pick the quota field of the requesting core
   always_comb begin
      quota_raw = '0;
      for (int c = 0; c < NCORES; c++) begin
         if (core == CW'(c)) quota_raw = quota_vec[c*QW +: QW];
      end
   end

   // clamp the quota into 1..WAYS and turn it into a slot number
   always_comb begin
      if (quota_raw == '0)
         quota_eff = 1;
      else if (int'(quota_raw) >= WAYS)
         quota_eff = WAYS;
      else
         quota_eff = int'(quota_raw);
      ins_slot = WW'(WAYS - quota_eff);
   end

endmodule

// File: rtl/pipp_way_locate.sv
module pipp_way_locate #(
   parameter int WAYS = 8,
   localparam int WW  = $clog2(WAYS)
) (
   input  logic [WAYS*WW-1:0] rank_flat,
   input  logic [WW-1:0]      way,
   output logic [WAYS-1:0]    match_oh,
   output logic [WW-1:0]      slot
);

   localparam bool_pow2 = ((1 << WW) == WAYS);

   genvar i;
   generate
      for (i = 0; i < WAYS; i++) begin : g_cmp
         assign match_oh[i] = (rank_flat[i*WW +: WW] == way);
      end

      if (bool_pow2) begin : g_or_enc
         // one-hot to binary: OR of slot numbers whose bit is set
         always_comb begin
            slot = '0;
            for (int s = 0; s < WAYS; s++) begin
               if (match_oh[s]) slot = slot | WW'(s);
            end
         end
      end else begin : g_prio_enc
         always_comb begin
            slot = '0;
            for (int s = WAYS - 1; s >= 0; s--) begin
               if (match_oh[s]) slot = WW'(s);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pipp_stack_next.sv
module pipp_stack_next
   import pipp_pkg::*;
#(
   parameter int WAYS = 8,
   localparam int WW  = $clog2(WAYS)
) (
   input  logic [WAYS*WW-1:0] cur_flat,
   input  stack_op_e          op,
   input  logic [WW-1:0]      ins_slot,
   input  logic [WW-1:0]      hit_slot,
   output logic [WAYS*WW-1:0] nxt_flat
);

   logic [WW-1:0] cur   [WAYS];
   logic [WW-1:0] nxt   [WAYS];
   logic [WW-1:0] lru_way;

   genvar i;
   generate
      for (i = 0; i < WAYS; i++) begin : g_unpack
         assign cur[i]                = cur_flat[i*WW +: WW];
         assign nxt_flat[i*WW +: WW]  = nxt[i];
      end
   endgenerate

   assign lru_way = cur[WAYS-1];

   generate
      for (i = 0; i < WAYS; i++) begin : g_slot
         localparam logic [WW-1:0] ME = WW'(i);
         logic [WW-1:0] miss_val;
         logic [WW-1:0] hit_val;

         // miss path: above the insert slot keep, at it place the victim,
         // below it take the neighbour from one slot up
         if (i == 0) begin : g_miss_top
            assign miss_val = (ins_slot == ME) ? lru_way : cur[i];
         end else begin : g_miss_rest
            assign miss_val = (ME < ins_slot)  ? cur[i]   :
                              (ME == ins_slot) ? lru_way  : cur[i-1];
         end

         // hit path: exchange with the slot directly above
         if (i == 0 && WAYS > 1) begin : g_hit_top
            assign hit_val = (hit_slot == WW'(1)) ? cur[1] : cur[0];
         end else if (i == WAYS - 1) begin : g_hit_bot
            assign hit_val = (hit_slot == ME) ? cur[i-1] : cur[i];
         end else begin : g_hit_mid
            assign hit_val = (hit_slot == WW'(i + 1)) ? cur[i+1] :
                             (hit_slot == ME)         ? cur[i-1] : cur[i];
         end

         always_comb begin
            unique case (op)
               OP_MISS: nxt[i] = miss_val;
               OP_HIT:  nxt[i] = hit_val;
               default: nxt[i] = cur[i];
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/pipp_set_ctrl.sv
module pipp_set_ctrl
   import pipp_pkg::*;
#(
   parameter int WAYS   = 8,
   parameter int NCORES = 2,
   parameter int QW     = 4,
   localparam int WW    = $clog2(WAYS),
   localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [CW-1:0]        req_core,
   input  logic                 req_hit,
   input  logic [WW-1:0]        hit_way,
   input  logic [NCORES*QW-1:0] quota_vec,
   output logic [WW-1:0]        victim_way,
   output logic [WAYS*WW-1:0]   rank_vec
);

   initial begin
      assert (WAYS >= 2) else $error("pipp_set_ctrl: WAYS must be at least 2");
      assert (NCORES >= 1) else $error("pipp_set_ctrl: NCORES must be at least 1");
      assert (QW >= 1 && QW <= 16) else $error("pipp_set_ctrl: QW out of range");
   end

   logic [WAYS*WW-1:0] rank_q;
   logic [WAYS*WW-1:0] rank_d;
   logic [WAYS*WW-1:0] rank_init;
   logic [WW-1:0]      ins_slot;
   logic [WW-1:0]      hit_slot;
   logic [WAYS-1:0]    hit_oh;
   stack_op_e          op;

   genvar i;
   generate
      for (i = 0; i < WAYS; i++) begin : g_init
         assign rank_init[i*WW +: WW] = WW'(i);
      end
   endgenerate

   assign op = classify(req_valid, req_hit);

   pipp_quota_sel #(.WAYS(WAYS), .NCORES(NCORES), .QW(QW)) u_qsel (
      .core      (req_core),
      .quota_vec (quota_vec),
      .ins_slot  (ins_slot)
   );

   pipp_way_locate #(.WAYS(WAYS)) u_loc (
      .rank_flat (rank_q),
      .way       (hit_way),
      .match_oh  (hit_oh),
      .slot      (hit_slot)
   );

   pipp_stack_next #(.WAYS(WAYS)) u_next (
      .cur_flat (rank_q),
      .op       (op),
      .ins_slot (ins_slot),
      .hit_slot (hit_slot),
      .nxt_flat (rank_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rank_q <= rank_init;
      else        rank_q <= rank_d;
   end

   assign rank_vec   = rank_q;
   assign victim_way = rank_q[(WAYS-1)*WW +: WW];

endmodule

// File: rtl/pipp_set_chk.sv
module pipp_set_chk #(
   parameter int WAYS   = 8,
   parameter int NCORES = 2,
   parameter int QW     = 4,
   localparam int WW    = $clog2(WAYS),
   localparam int CW    = (NCORES > 1) ? $clog2(NCORES) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [CW-1:0]        req_core,
   input logic                 req_hit,
   input logic [WW-1:0]        hit_way,
   input logic [NCORES*QW-1:0] quota_vec,
   input logic [WW-1:0]        victim_way,
   input logic [WAYS*WW-1:0]   rank_vec
);

   function automatic logic [WW-1:0] slot_of(input logic [WAYS*WW-1:0] r, input int s);
      return r[s*WW +: WW];
   endfunction

   int            exp_ins;
   int            exp_pos;
   logic [WAYS-1:0] present;

   always_comb begin
      int q;
      q = int'(quota_vec[int'(req_core)*QW +: QW]);
      if (q < 1) q = 1;
      if (q > WAYS) q = WAYS;
      exp_ins = WAYS - q;
   end

   always_comb begin
      exp_pos = 0;
      for (int s = 0; s < WAYS; s++) begin
         if (slot_of(rank_vec, s) == hit_way) exp_pos = s;
      end
   end

   always_comb begin
      present = '0;
      for (int s = 0; s < WAYS; s++) present[slot_of(rank_vec, s)] = 1'b1;
   end

   // R3
   miss_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_hit) |=> (slot_of(rank_vec, $past(exp_ins)) == $past(victim_way)));

   // R7
   hit_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_hit && exp_pos > 0) |=>
      (slot_of(rank_vec, $past(exp_pos) - 1) == $past(hit_way)));

   // R8
   mru_hit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_hit && exp_pos == 0) |=> $stable(rank_vec));

   // R9
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid) |=> $stable(rank_vec));

   // R11
   perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(present) == WAYS);

endmodule

bind pipp_set_ctrl pipp_set_chk #(.WAYS(WAYS), .NCORES(NCORES), .QW(QW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_core   (req_core),
   .req_hit    (req_hit),
   .hit_way    (hit_way),
   .quota_vec  (quota_vec),
   .victim_way (victim_way),
   .rank_vec   (rank_vec)
);

// File: tb/pipp_set_ctrl_bench.sv
module pipp_set_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WAYS = 8;
   localparam int NC   = 2;
   localparam int QW   = 4;
   localparam int WW   = 3;
   localparam int CW   = 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 req_valid = 1'b0;
   logic [CW-1:0]        req_core = '0;
   logic                 req_hit = 1'b0;
   logic [WW-1:0]        hit_way = '0;
   logic [NC*QW-1:0]     quota_vec = '0;
   logic [WW-1:0]        victim_way;
   logic [WAYS*WW-1:0]   rank_vec;

   int n_checks = 0;
   int n_fail   = 0;
   int exp_rank [WAYS];
   int quota    [NC];
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipp_set_ctrl #(.WAYS(WAYS), .NCORES(NC), .QW(QW)) u_pipp_set_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
      .req_hit(req_hit), .hit_way(hit_way), .quota_vec(quota_vec),
      .victim_way(victim_way), .rank_vec(rank_vec)
   );

   function automatic int dut_slot(int s);
      return int'(rank_vec[s*WW +: WW]);
   endfunction

   function automatic int eff_quota(int q);
      if (q < 1) return 1;
      if (q > WAYS) return WAYS;
      return q;
   endfunction

   task automatic model_miss(int core);
      int v = exp_rank[WAYS-1];
      int p = WAYS - eff_quota(quota[core]);
      for (int i = WAYS - 1; i > p; i--) exp_rank[i] = exp_rank[i-1];
      exp_rank[p] = v;
   endtask

   task automatic model_hit(int way);
      int k = 0;
      for (int i = 0; i < WAYS; i++) if (exp_rank[i] == way) k = i;
      if (k > 0) begin
         int t = exp_rank[k-1];
         exp_rank[k-1] = exp_rank[k];
         exp_rank[k] = t;
      end
   endtask

   task automatic check_order(string tag);
      int bad = -1;
      int seen = 0;
      n_checks++;
      for (int i = 0; i < WAYS; i++) if (bad < 0 && dut_slot(i) != exp_rank[i]) bad = i;
      if (bad >= 0) begin
         n_fail++;
         $display("FAIL %s: slot %0d actual %0d expected %0d", tag, bad, dut_slot(bad), exp_rank[bad]);
      end
      n_checks++;
      for (int i = 0; i < WAYS; i++) seen |= (1 << dut_slot(i));
      if (seen != (1 << WAYS) - 1) begin
         n_fail++;
         $display("FAIL R11: way mask actual %0h expected %0h", seen, (1 << WAYS) - 1);
      end
   endtask

   task automatic set_quotas(int q0, int q1);
      quota[0] = q0;
      quota[1] = q1;
      quota_vec = {QW'(q1), QW'(q0)};
   endtask

   // starts and ends just after a falling edge
   task automatic do_op(bit valid, int core, bit hit, int way, string tag);
      req_valid = valid;
      req_core  = CW'(core);
      req_hit   = hit;
      hit_way   = WW'(way);
      #1;
      n_checks++;
      if (int'(victim_way) != exp_rank[WAYS-1]) begin
         n_fail++;
         $display("FAIL R2: victim actual %0d expected %0d", victim_way, exp_rank[WAYS-1]);
      end
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      if (valid && hit)  model_hit(way);
      if (valid && !hit) model_miss(core);
      @(negedge clk);
      check_order(tag);
   endtask

   initial begin
      int wd = 0;
      while (!done && wd < 20000) begin
         @(posedge clk);
         wd++;
      end
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4177));
      for (int i = 0; i < WAYS; i++) exp_rank[i] = i;
      set_quotas(5, 3);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_order("R1 reset order");

      // R4 / R3: worked case with quotas 5 and 3
      do_op(1, 1, 0, 0, "R3 R4 core1 miss quota3");
      do_op(1, 0, 0, 0, "R3 R4 core0 miss quota5");
      do_op(1, 1, 0, 0, "R3 core1 miss again");
      // R9: idle with junk inputs
      do_op(0, 1, 0, 5, "R9 idle miss pattern");
      do_op(0, 0, 1, 6, "R9 idle hit pattern");
      // R5: quota zero
      set_quotas(0, 3);
      do_op(1, 0, 0, 0, "R5 zero quota");
      // R6: oversized quota and exact WAYS
      set_quotas(12, 8);
      do_op(1, 0, 0, 0, "R6 quota above ways");
      do_op(1, 1, 0, 0, "R6 quota equal ways");
      // R8: hit at MRU
      do_op(1, 0, 1, exp_rank[0], "R8 hit at mru");
      // R7: hit at LRU and middle
      do_op(1, 1, 1, exp_rank[WAYS-1], "R7 hit at lru");
      do_op(1, 0, 1, exp_rank[3], "R7 hit middle");
      do_op(1, 0, 1, exp_rank[1], "R7 hit slot1");

      // R10: random mix, each update checked one edge later
      for (int n = 0; n < 500; n++) begin
         int c = int'($urandom_range(1, 0));
         bit v = ($urandom_range(9, 0) != 0);
         bit h = $urandom_range(1, 0);
         int w = int'($urandom_range(WAYS - 1, 0));
         if ($urandom_range(15, 0) == 0)
            set_quotas(int'($urandom_range(15, 0)), int'($urandom_range(15, 0)));
         do_op(v, c, h, w, !v ? "R9 R10 random idle" : (h ? "R7 R10 random hit" : "R3 R10 random miss"));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule